// File: doc/BRIEF.md
# Prefixed Instruction Length Decoder

This block is the byte-serial front end of an instruction fetch path. It takes one instruction byte per handshake from a valid/ready stream and works out where each instruction ends. A first byte outside the prefix range is a complete one-byte basic instruction. A first byte inside the prefix range opens an extended instruction. That prefix names the first operand and may be followed by its own operand bytes. After them comes an operation byte, which names the operation and the second operand, and then any trailing source bytes.

When an instruction is complete, the block presents one bundle on a valid/ready output. The bundle holds an extended flag, the prefix, the first-operand bytes, the operation byte, the second-operand bytes and the total byte count. The decoder holds one instruction at a time. While a bundle waits for the consumer, the input is held off, so no byte is dropped. What the operation means is left to later stages.

Top module: `pfx_instr_decoder`

## Requirements
- R1: While reset is asserted and right after it, `outValid` is 0 and `inReady` is 1.
- R2: A first byte in 0xE0..0xFE (inclusive) starts an extended instruction and gives `outIsExt`=1. Every other first byte, 0xDF and 0xFF included, gives a basic instruction with `outIsExt`=0.
- R3: A basic bundle has `outLen`=1, `outOpcode` equal to the byte, and `outPrefix`, `outOpnd1` and `outOpnd2` all zero.
- R4: The number of first-operand bytes after a prefix is set by prefix bits [4:3]: 01 (0xE8..0xEF) gives 2, 10 (0xF0..0xF7) gives 1, and 00 or 11 gives 0.
- R5: The number of trailing bytes after the operation byte is 0 for operation bytes below 0xC0, 1 for 0xC0..0xDF and 2 for 0xE0..0xFF. An operation byte in the prefix range is never taken as a new prefix.
- R6: Operand bytes are packed first-received into bits [7:0] and second into bits [15:8]. Byte lanes that are not used read zero.
- R7: An extended bundle has `outLen` = 2 + first-operand count + trailing count. For example, E8 34 12 C5 7F gives length 5, `outOpnd1`=0x1234, `outOpcode`=0xC5 and `outOpnd2`=0x007F.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1, every bundle field stays unchanged and `inReady` is 0. No input byte is lost or repeated.
- R9: `outValid` is 1 in the cycle right after the last byte of an instruction is accepted. `inReady` is 1 in the cycle right after the bundle handshake.
- R10: Cycles with `inValid`=0 have no effect, whatever the value on `inData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte is valid |
| inData | input | 8 | Instruction byte |
| inReady | output | 1 | Decoder accepts a byte this cycle |
| outValid | output | 1 | Bundle is valid |
| outReady | input | 1 | Consumer takes the bundle |
| outIsExt | output | 1 | 1 for an extended instruction |
| outPrefix | output | 8 | Prefix byte, 0 for a basic instruction |
| outOpnd1 | output | 16 | First-operand bytes, packed per R6 |
| outOpcode | output | 8 | Operation byte, or the basic byte |
| outOpnd2 | output | 16 | Trailing source bytes, packed per R6 |
| outLen | output | 3 | Total instruction length in bytes |

## Verification
Every bundle appears exactly one cycle after the edge that accepts its last byte. The bench therefore marks that byte when it builds the stream, and it requires `outValid` at the very next sampling point. `inReady` must return in the cycle after the edge that completes an output handshake, and the bench checks it there. All handshakes are judged one time step after the falling edge, when inputs and registered outputs are both settled. While the output is stalled, the bundle seen in one cycle is compared with the bundle seen in the next.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PFX_OPND,
    ST_OPCODE,
    ST_SRC_OPND,
    ST_EMIT
  } pidState_e;

  // one strobe per datapath load action; at most one is high per cycle
  typedef struct packed {
    logic ldBasic;
    logic ldPrefix;
    logic ldOpnd1;
    logic ldOpcode;
    logic ldOpnd2;
  } pidStrobe_t;

  // first-operand byte count, from prefix bits [4:3]
  function automatic logic [1:0] prefixOpndCount(input logic [1:0] sel);
    case (sel)
      2'b01:   return 2'd2;
      2'b10:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // trailing source byte count, from operation bits [7:5]
  function automatic logic [1:0] trailCount(input logic [2:0] top);
    if (top[2:1] != 2'b11) return 2'd0;
    if (top[0]) return 2'd2;
    return 2'd1;
  endfunction

endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
#(
  parameter logic [7:0] PFX_LO = 8'hE0,
  parameter logic [7:0] PFX_HI = 8'hFE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output pidStrobe_t strobe
);

  pidState_e  stateQ, stateD;
  logic [1:0] remainQ, remainD;
  logic       take;
  logic       isPrefix;
  logic [1:0] pfxCnt;
  logic [1:0] trlCnt;

  assign inReady  = (stateQ != ST_EMIT);
  assign outValid = (stateQ == ST_EMIT);
  assign take     = inValid && inReady;
  assign isPrefix = (inData >= PFX_LO) && (inData <= PFX_HI);
  assign pfxCnt   = prefixOpndCount(inData[4:3]);
  assign trlCnt   = trailCount(inData[7:5]);

  always_comb begin
    stateD  = stateQ;
    remainD = remainQ;
    strobe  = '0;
    case (stateQ)
      ST_IDLE: begin
        if (take) begin
          if (isPrefix) begin
            strobe.ldPrefix = 1'b1;
            remainD = pfxCnt;
            stateD  = (pfxCnt == 2'd0) ? ST_OPCODE : ST_PFX_OPND;
          end else begin
            strobe.ldBasic = 1'b1;
            stateD = ST_EMIT;
          end
        end
      end
      ST_PFX_OPND: begin
        if (take) begin
          strobe.ldOpnd1 = 1'b1;
          remainD = remainQ - 2'd1;
          if (remainQ == 2'd1) stateD = ST_OPCODE;
        end
      end
      ST_OPCODE: begin
        if (take) begin
          strobe.ldOpcode = 1'b1;
          remainD = trlCnt;
          stateD  = (trlCnt == 2'd0) ? ST_EMIT : ST_SRC_OPND;
        end
      end
      ST_SRC_OPND: begin
        if (take) begin
          strobe.ldOpnd2 = 1'b1;
          remainD = remainQ - 2'd1;
          if (remainQ == 2'd1) stateD = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (outReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remainQ <= 2'd0;
    end else begin
      stateQ  <= stateD;
      remainQ <= remainD;
    end
  end

  // R8: a stalled bundle stays valid
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R9: input reopens right after the output handshake
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady |=> inReady && !outValid);

  // R9: the last trailing byte leads straight to a bundle
  a_r9_emit_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SRC_OPND) && take && (remainQ == 2'd1) |=> outValid);

  // R2: a non-prefix first byte goes straight to a bundle
  a_r2_basic_direct: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) && take && !isPrefix |=> outValid);

  // R4: the operand-collecting states never run with no bytes left
  a_r4_remain_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PFX_OPND || stateQ == ST_SRC_OPND) |-> remainQ != 2'd0);

endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter  int MAX_OPND = 2,
  localparam int OPND_W   = BYTE_W * MAX_OPND,
  localparam int LEN_W    = $clog2(2 * MAX_OPND + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pidStrobe_t        strobe,
  input  logic [7:0]        inData,
  output logic              isExt,
  output logic [7:0]        prefix,
  output logic [OPND_W-1:0] opnd1,
  output logic [7:0]        opcode,
  output logic [OPND_W-1:0] opnd2,
  output logic [LEN_W-1:0]  len
);

  localparam int IDX_W = $clog2(MAX_OPND + 1);

  logic             start;
  logic [IDX_W-1:0] idx1Q, idx2Q;

  assign start = strobe.ldBasic || strobe.ldPrefix;

  for (genvar g = 0; g < MAX_OPND; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opnd1[g*BYTE_W +: BYTE_W] <= '0;
        opnd2[g*BYTE_W +: BYTE_W] <= '0;
      end else begin
        if (start)
          opnd1[g*BYTE_W +: BYTE_W] <= '0;
        else if (strobe.ldOpnd1 && idx1Q == IDX_W'(g))
          opnd1[g*BYTE_W +: BYTE_W] <= inData;
        if (start)
          opnd2[g*BYTE_W +: BYTE_W] <= '0;
        else if (strobe.ldOpnd2 && idx2Q == IDX_W'(g))
          opnd2[g*BYTE_W +: BYTE_W] <= inData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx1Q  <= '0;
      idx2Q  <= '0;
      isExt  <= 1'b0;
      prefix <= '0;
      opcode <= '0;
      len    <= '0;
    end else begin
      if (start) begin
        idx1Q  <= '0;
        idx2Q  <= '0;
        isExt  <= strobe.ldPrefix;
        prefix <= strobe.ldPrefix ? inData : 8'h00;
        len    <= LEN_W'(1);
      end else if (strobe.ldOpnd1 || strobe.ldOpcode || strobe.ldOpnd2) begin
        len <= len + LEN_W'(1);
      end
      if (strobe.ldOpnd1) idx1Q <= idx1Q + IDX_W'(1);
      if (strobe.ldOpnd2) idx2Q <= idx2Q + IDX_W'(1);
      if (strobe.ldBasic || strobe.ldOpcode) opcode <= inData;
    end
  end

  // R6: operand loads never index past the last lane
  a_r6_lane1_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOpnd1 |-> idx1Q < IDX_W'(MAX_OPND));
  a_r6_lane2_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOpnd2 |-> idx2Q < IDX_W'(MAX_OPND));

  // R2: the control never asks for two load actions at once
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/pfx_instr_decoder.sv
module pfx_instr_decoder
  import pid_pkg::*;
#(
  parameter  int         MAX_OPND = 2,
  parameter  logic [7:0] PFX_LO   = 8'hE0,
  parameter  logic [7:0] PFX_HI   = 8'hFE,
  localparam int         OPND_W   = BYTE_W * MAX_OPND,
  localparam int         LEN_W    = $clog2(2 * MAX_OPND + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsExt,
  output logic [7:0]        outPrefix,
  output logic [OPND_W-1:0] outOpnd1,
  output logic [7:0]        outOpcode,
  output logic [OPND_W-1:0] outOpnd2,
  output logic [LEN_W-1:0]  outLen
);

  pidStrobe_t strobe;

  pid_ctrl #(
    .PFX_LO(PFX_LO),
    .PFX_HI(PFX_HI)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  pid_datapath #(
    .MAX_OPND(MAX_OPND)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inData (inData),
    .isExt  (outIsExt),
    .prefix (outPrefix),
    .opnd1  (outOpnd1),
    .opcode (outOpcode),
    .opnd2  (outOpnd2),
    .len    (outLen)
  );

  // R8: the bundle is frozen while it waits
  a_r8_stable_bundle: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=>
      $stable({outIsExt, outPrefix, outOpnd1, outOpcode, outOpnd2, outLen}));

  // R3: shape of a basic bundle
  a_r3_basic_shape: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIsExt |->
      outLen == LEN_W'(1) && outPrefix == 8'h00 && outOpnd1 == '0 && outOpnd2 == '0);

  // R2: an extended bundle always carries an in-range prefix
  a_r2_prefix_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIsExt |-> outPrefix >= PFX_LO && outPrefix <= PFX_HI);

  // R7: length agrees with the two byte-count lookups
  a_r7_ext_len: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIsExt |->
      outLen == LEN_W'(2 + int'(prefixOpndCount(outPrefix[4:3]))
                         + int'(trailCount(outOpcode[7:5]))));

endmodule

// File: tb/sim_pfx_instr_decoder.sv
`timescale 1ns/100ps
module sim_pfx_instr_decoder;

  typedef struct packed {
    logic        ext;
    logic [7:0]  pfx;
    logic [15:0] o1;
    logic [7:0]  op;
    logic [15:0] o2;
    logic [2:0]  len;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outIsExt;
  logic [7:0]  outPrefix, outOpcode;
  logic [15:0] outOpnd1, outOpnd2;
  logic [2:0]  outLen;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit timedOut = 0;
  localparam int WATCHDOG = 150000;

  logic [7:0] byteQ[$];
  bit         lastQ[$];
  exp_t       expQ[$];

  always #2.5 clk = ~clk;

  pfx_instr_decoder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outIsExt(outIsExt), .outPrefix(outPrefix),
    .outOpnd1(outOpnd1), .outOpcode(outOpcode), .outOpnd2(outOpnd2), .outLen(outLen)
  );

  function automatic int expPfxN(input logic [7:0] p);
    if (p >= 8'hE8 && p <= 8'hEF) return 2;
    if (p >= 8'hF0 && p <= 8'hF7) return 1;
    return 0;
  endfunction

  function automatic int expOpN(input logic [7:0] op);
    if (op >= 8'hE0) return 2;
    if (op >= 8'hC0) return 1;
    return 0;
  endfunction

  function automatic exp_t curBundle();
    exp_t c;
    c.ext = outIsExt; c.pfx = outPrefix; c.o1 = outOpnd1;
    c.op = outOpcode; c.o2 = outOpnd2; c.len = outLen;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic addInstr(input logic [7:0] first, input logic [15:0] a,
                          input logic [7:0] op, input logic [15:0] s);
    exp_t e;
    int n1, n2;
    e = '0;
    if (first >= 8'hE0 && first <= 8'hFE) begin
      n1 = expPfxN(first);
      n2 = expOpN(op);
      e.ext = 1'b1; e.pfx = first; e.op = op;
      byteQ.push_back(first); lastQ.push_back(1'b0);
      for (int i = 0; i < n1; i++) begin
        byteQ.push_back(a[8*i +: 8]); lastQ.push_back(1'b0);
        e.o1[8*i +: 8] = a[8*i +: 8];
      end
      byteQ.push_back(op); lastQ.push_back(n2 == 0);
      for (int i = 0; i < n2; i++) begin
        byteQ.push_back(s[8*i +: 8]); lastQ.push_back(i == n2 - 1);
        e.o2[8*i +: 8] = s[8*i +: 8];
      end
      e.len = 3'(2 + n1 + n2);
    end else begin
      e.op = first; e.len = 3'd1;
      byteQ.push_back(first); lastQ.push_back(1'b1);
    end
    expQ.push_back(e);
  endtask

  task automatic addRandom(input int count);
    for (int k = 0; k < count; k++) begin
      logic [7:0] f;
      if ($urandom % 2) f = 8'hE0 + 8'($urandom % 31);
      else begin
        f = 8'($urandom % 225);
        if (f == 8'hE0) f = 8'hFF;
      end
      addInstr(f, 16'($urandom), 8'($urandom), 16'($urandom));
    end
  endtask

  task automatic runStream(input int gapPct, input int stallPct);
    bit   dueValid = 0, dueReady = 0, held = 0;
    exp_t heldB = '0;
    while (expQ.size() > 0) begin
      @(negedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        timedOut = 1;
        chk(0, "watchdog expired", 64'(cycles), 64'(WATCHDOG));
        break;
      end
      if (dueValid) chk(outValid == 1'b1, "R9 outValid after last byte", 64'(outValid), 64'd1);
      if (dueReady) chk(inReady == 1'b1, "R9 inReady after handshake", 64'(inReady), 64'd1);
      if (held) chk(outValid && curBundle() == heldB, "R8 stalled bundle held",
                    64'(curBundle()), 64'(heldB));
      dueValid = 0; dueReady = 0;
      inValid  = (byteQ.size() > 0) && (($urandom % 100) >= gapPct);
      inData   = inValid ? byteQ[0] : 8'($urandom);
      outReady = ($urandom % 100) >= stallPct;
      #1;
      if (outValid) chk(!inReady, "R8 input closed while full", 64'(inReady), 64'd0);
      if (inValid && inReady) begin
        if (lastQ[0]) dueValid = 1;
        void'(byteQ.pop_front());
        void'(lastQ.pop_front());
      end
      if (outValid && outReady) begin
        exp_t e;
        e = expQ.pop_front();
        chk(outIsExt == e.ext, "R2 instruction class", 64'(outIsExt), 64'(e.ext));
        chk({outPrefix, outOpnd1, outOpcode, outOpnd2} == {e.pfx, e.o1, e.op, e.o2},
            e.ext ? "R6 R5 extended fields" : "R3 basic fields",
            {outPrefix, outOpnd1, outOpcode, outOpnd2}, {e.pfx, e.o1, e.op, e.o2});
        chk(outLen == e.len, e.ext ? "R4 R5 R7 length" : "R3 length",
            64'(outLen), 64'(e.len));
        dueReady = 1;
      end
      held  = outValid && !outReady;
      heldB = curBundle();
    end
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R1 inReady in reset", 64'(inReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && inReady == 1'b1, "R1 state after reset",
        64'({outValid, inReady}), 64'b01);

    // R10: prefix-looking data with inValid low is ignored
    inValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      inData = (i % 2) ? 8'hE8 : 8'h3C;
      @(negedge clk);
    end
    chk(outValid == 1'b0 && inReady == 1'b1, "R10 idle data ignored",
        64'({outValid, inReady}), 64'b01);

    // directed corners (R2 R4 R5 R6 R7)
    addInstr(8'hE8, 16'h1234, 8'hC5, 16'h007F);   // two address bytes, op, one immediate
    addInstr(8'hDF, 16'h0, 8'h0, 16'h0);          // just below prefix range
    addInstr(8'hFF, 16'h0, 8'h0, 16'h0);          // just above prefix range
    addInstr(8'hE0, 16'h0, 8'h00, 16'h0);         // smallest extended: length 2
    addInstr(8'hFE, 16'h0, 8'hFF, 16'hBEEF);      // op in high range, two trailing
    addInstr(8'hF3, 16'h00A5, 8'hE5, 16'h5AC3);   // op inside prefix range is not a prefix
    addInstr(8'hEF, 16'hCAFE, 8'hBF, 16'h0);      // op just below one-byte trailing range
    addInstr(8'hF7, 16'h0011, 8'hDF, 16'h0022);   // one-byte first operand, one trailing
    addInstr(8'hF8, 16'h0, 8'hC0, 16'h0099);      // no first operand
    runStream(0, 0);
    addInstr(8'hE9, 16'h7788, 8'hE1, 16'h1122);
    addInstr(8'h42, 16'h0, 8'h0, 16'h0);
    addInstr(8'hF1, 16'h0066, 8'h10, 16'h0);
    runStream(0, 60);                             // R8 stalls on directed set

    addRandom(300);
    runStream(30, 30);
    addRandom(150);
    runStream(0, 0);                              // back-to-back
    addRandom(150);
    runStream(70, 70);                            // R10 with long gaps

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule